// File: doc/BRIEF.md
# Write-Strobe Qualifier with Inhibit Gating

This block sits between the raw, asynchronous chip-select, output-enable and write-enable pins of a parallel memory-style bus and the command decoder behind it. It brings the three active-low control pins and a digital supply-low indication into the clock domain through synchronizer chains. It emits one clean, one-clock write pulse, with the captured address and data beside it, only for a genuine write cycle.

A write cycle is the interval in which chip-select and write-enable are both low. It opens at whichever of the two falls later and closes when either one rises. The cycle is rejected for four reasons. It may be shorter than a minimum clock count, which is how glitches are filtered. Output-enable may go low at any point inside it. The supply-low input may be asserted. Or the power-on write lockout may still be running. That lockout counts a fixed number of clocks with the supply reported good, and it starts again from zero each time supply-low asserts. The analog detector that drives supply-low is outside the block.

The address and data pins pass through a delay line matched to the control synchronizers. The values reported are the ones present in the last sampled clock of the cycle, just before the strobe rises.

Top module: `wr_strobe_qual`

## Requirements
- R1: A write cycle whose synchronized length (clocks with chip-select and write-enable both low) is below MIN_PULSE produces no pulse. A length of exactly MIN_PULSE or more produces one.
- R2: A cycle produces no pulse if output-enable is low in any sampled clock of the cycle or at its end. Write-enable low with chip-select high never produces a pulse.
- R3: A cycle produces no pulse if supply-low is asserted at any sampled clock during the cycle or at its end.
- R4: After reset, writes are blocked until supply-low has read deasserted for PWRUP_CYCLES consecutive synchronized clocks.
- R5: Any assertion of supply-low restarts the lockout count from zero. Writes stay blocked for a further PWRUP_CYCLES clocks after it deasserts.
- R6: Each accepted cycle yields exactly one wr_pulse, high for one clock.
- R7: wr_addr and wr_data carry the address and data sampled in the last clock of the accepted cycle. They keep their value when no pulse is issued.
- R8: Cycle length counts from the later of the two falling edges. Either chip-select or write-enable rising ends the cycle.
- R9: In reset, wr_pulse, wr_addr and wr_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr_in | input | ADDR_W | Bus address |
| data_in | input | DATA_W | Bus write data |
| supply_low | input | 1 | Supply below write threshold, asynchronous |
| wr_pulse | output | 1 | One-clock qualified write strobe |
| wr_addr | output | ADDR_W | Address of the qualified write |
| wr_data | output | DATA_W | Data of the qualified write |

## Verification
Assertions check, on every clock, that each pulse lasts one clock. They also check that a pulse follows only a cycle that reached MIN_PULSE, ended with output-enable high, supply good and lockout elapsed, and was closed by a rising chip-select or write-enable. Further checks are that supply-low clears the lockout and that the outputs hold between pulses. Only the bench's scenarios can show which cycles are accepted or rejected. That covers the width boundary, the lead time before the later falling edge, output-enable or supply-low pulses in mid-cycle, and the lockout windows. They also show that the captured data is the late value and not the early one.

// File: rtl/wr_strobe_qual.sv
module wr_strobe_qual #(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 16,
  parameter int SYNC_STAGES  = 2,
  parameter int MIN_PULSE    = 2,
  parameter int PWRUP_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              supply_low,
  output logic              wr_pulse,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int WCNT_W = $clog2(MIN_PULSE + 1);
  localparam int LCNT_W = $clog2(PWRUP_CYCLES + 1);
  localparam int LAST   = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] ce_sh, oe_sh, we_sh, sl_sh;
  logic [ADDR_W-1:0]      addr_dl [SYNC_STAGES];
  logic [DATA_W-1:0]      data_dl [SYNC_STAGES];
  logic [WCNT_W-1:0]      wcnt;
  logic [LCNT_W-1:0]      lock_cnt;
  logic [ADDR_W-1:0]      addr_q;
  logic [DATA_W-1:0]      data_q;
  logic                   in_cycle_q, spoiled;

  wire ce_s      = ce_sh[LAST];
  wire oe_s      = oe_sh[LAST];
  wire we_s      = we_sh[LAST];
  wire sl_s      = sl_sh[LAST];
  wire in_cycle  = !ce_s && !we_s;
  wire lock_done = (lock_cnt == LCNT_W'(PWRUP_CYCLES));
  wire long_enough = (wcnt == WCNT_W'(MIN_PULSE));
  wire commit    = in_cycle_q && !in_cycle && !spoiled && long_enough
                   && oe_s && !sl_s && lock_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_sh <= '1;
      oe_sh <= '1;
      we_sh <= '1;
      sl_sh <= '1;
      for (int i = 0; i < SYNC_STAGES; i++) begin
        addr_dl[i] <= '0;
        data_dl[i] <= '0;
      end
    end else begin
      ce_sh <= {ce_sh[SYNC_STAGES-2:0], ce_n};
      oe_sh <= {oe_sh[SYNC_STAGES-2:0], oe_n};
      we_sh <= {we_sh[SYNC_STAGES-2:0], we_n};
      sl_sh <= {sl_sh[SYNC_STAGES-2:0], supply_low};
      addr_dl[0] <= addr_in;
      data_dl[0] <= data_in;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        addr_dl[i] <= addr_dl[i-1];
        data_dl[i] <= data_dl[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_cnt <= '0;
    else if (sl_s) lock_cnt <= '0;
    else if (!lock_done) lock_cnt <= lock_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cycle_q <= 1'b0;
      wcnt       <= '0;
      spoiled    <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
    end else begin
      in_cycle_q <= in_cycle;
      if (in_cycle) begin
        if (!long_enough) wcnt <= wcnt + 1'b1;
        addr_q <= addr_dl[LAST];
        data_q <= data_dl[LAST];
        if (!oe_s || sl_s || !lock_done) spoiled <= 1'b1;
      end else begin
        wcnt    <= '0;
        spoiled <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_pulse <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_pulse <= commit;
      if (commit) begin
        wr_addr <= addr_q;
        wr_data <= data_q;
      end
    end
  end

  p_min_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(wcnt) == WCNT_W'(MIN_PULSE));
  p_oe_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(oe_s));
  p_supply_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> !$past(sl_s));
  p_lock_elapsed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(lock_done));
  p_lock_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sl_s |=> !lock_done);
  p_single_clock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);
  p_hold_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pulse |-> $stable(wr_addr) && $stable(wr_data));
  p_end_by_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> $past(ce_s || we_s) && $past(in_cycle_q));
endmodule

// File: tb/wr_strobe_qual_bench.sv
module wr_strobe_qual_bench;
  localparam int MINP = 3;
  localparam int LOCK = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, supply_low = 1'b0;
  logic [15:0] addr_in = '0, data_in = '0;
  logic wr_pulse;
  logic [15:0] wr_addr, wr_data;

  wr_strobe_qual #(.ADDR_W(16), .DATA_W(16), .SYNC_STAGES(2),
                   .MIN_PULSE(MINP), .PWRUP_CYCLES(LOCK)) u_wr_strobe_qual (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr_in(addr_in), .data_in(data_in), .supply_low(supply_low),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, pulses = 0, doubles = 0;
  logic [15:0] cap_a = '0, cap_d = '0;
  logic prev_p = 1'b0;
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n && wr_pulse) begin
      pulses++;
      cap_a = wr_addr;
      cap_d = wr_data;
      if (prev_p) doubles++;
    end
    prev_p = wr_pulse;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wcycle(input bit sec_ce, input int lead, input int width,
                        input bit oe_low, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    addr_in = a; data_in = d; oe_n = ~oe_low;
    if (sec_ce) we_n = 1'b0; else ce_n = 1'b0;
    repeat (lead) @(negedge clk);
    if (sec_ce) ce_n = 1'b0; else we_n = 1'b0;
    repeat (width) @(negedge clk);
    if (sec_ce) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // fields: second-is-ce, lead[3], width[4], oe_low, addr[16], data[16], expect
  localparam int NV = 8;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 3'd1, 4'd3,  1'b0, 16'h1234, 16'hA5A5, 1'b1},
    {1'b0, 3'd1, 4'd2,  1'b0, 16'h2222, 16'h0F0F, 1'b0},
    {1'b1, 3'd2, 4'd4,  1'b0, 16'h3456, 16'h5A5A, 1'b1},
    {1'b1, 3'd2, 4'd2,  1'b0, 16'h4444, 16'h1111, 1'b0},
    {1'b0, 3'd6, 4'd2,  1'b0, 16'h5555, 16'h2222, 1'b0},
    {1'b0, 3'd1, 4'd5,  1'b1, 16'h6666, 16'h3333, 1'b0},
    {1'b1, 3'd0, 4'd8,  1'b0, 16'hFFFF, 16'h0001, 1'b1},
    {1'b0, 3'd3, 4'd15, 1'b0, 16'h0000, 16'hFFFF, 1'b1}
  };

  function automatic string tag_of(input int i);
    case (i)
      0, 1: return "R1";
      2, 3, 4: return "R8";
      5: return "R2";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #(10 * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    chk("R9", {15'd0, wr_pulse}, 0);
    chk("R9", wr_addr, 0);
    chk("R9", wr_data, 0);
    rst_n = 1'b1;

    p0 = pulses;
    wcycle(1'b0, 1, 5, 1'b0, 16'hBEEF, 16'hCAFE);
    chk("R4", pulses - p0, 0);
    repeat (LOCK + 10) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v = VEC[i];
      p0 = pulses;
      wcycle(v[41], int'(v[40:38]), int'(v[37:34]), v[33], v[32:17], v[16:1]);
      chk(tag_of(i), pulses - p0, int'(v[0]));
      if (v[0]) begin
        chk("R7", cap_a, v[32:17]);
        chk("R7", cap_d, v[16:1]);
      end else begin
        chk("R7", wr_addr, cap_a);
      end
    end

    p0 = pulses;
    @(negedge clk);
    addr_in = 16'h0ABC; data_in = 16'h1111; ce_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk);
    data_in = 16'h2222;
    repeat (3) @(negedge clk);
    we_n = 1'b1; @(negedge clk); ce_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R7", pulses - p0, 1);
    chk("R7", cap_d, 16'h2222);

    p0 = pulses;
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk); oe_n = 1'b0;
    repeat (2) @(negedge clk); oe_n = 1'b1;
    repeat (3) @(negedge clk);
    we_n = 1'b1; @(negedge clk); ce_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R2", pulses - p0, 0);

    p0 = pulses;
    @(negedge clk);
    we_n = 1'b0;
    repeat (6) @(negedge clk);
    we_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R2", pulses - p0, 0);

    p0 = pulses;
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0;
    repeat (3) @(negedge clk); supply_low = 1'b1;
    repeat (3) @(negedge clk); supply_low = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1; @(negedge clk); ce_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R3", pulses - p0, 0);
    repeat (LOCK + 10) @(negedge clk);

    supply_low = 1'b1;
    p0 = pulses;
    wcycle(1'b0, 1, 5, 1'b0, 16'h7777, 16'h7777);
    chk("R3", pulses - p0, 0);
    supply_low = 1'b0;
    p0 = pulses;
    wcycle(1'b0, 1, 5, 1'b0, 16'h8888, 16'h8888);
    chk("R5", pulses - p0, 0);
    repeat (LOCK + 10) @(negedge clk);
    p0 = pulses;
    wcycle(1'b0, 1, 5, 1'b0, 16'h9999, 16'h4321);
    chk("R5", pulses - p0, 1);
    chk("R5", cap_a, 16'h9999);

    chk("R6", doubles, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule